// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic logic unit. Two operands and a three-bit operation code go in. A result, a zero flag, a signed overflow flag and a carry-out come out. The datapath is a chain of identical one-bit cells. Each cell computes AND, OR and a full-adder sum for its bit position. A per-cell selector then picks one of those values, or the comparison input that only bit 0 receives.

Subtraction reuses the same adder. A single "invert" line complements the second operand in every cell, and that same line also drives the carry into bit 0. Signed less-than comparison is built from the subtraction. The sign of the difference is corrected by the overflow indication and then fed back into bit 0, while every other bit of the result is forced to zero.

The zero flag is derived from the final result. This lets an equality test be made by subtracting and checking for zero. Operation codes that are not defined give a quiet all-zero result with no overflow and no carry.

Top module: `bitslice_alu`

## Requirements
- R1: Code 3'b000 gives the bitwise AND of `opa` and `opb`.
- R2: Code 3'b001 gives the bitwise OR of `opa` and `opb`.
- R3: Code 3'b010 gives `opa + opb` modulo 2^WIDTH. `carry_out` is the carry from the top bit.
- R4: Code 3'b110 gives `opa + ~opb + 1` modulo 2^WIDTH. `carry_out` is the carry from the top bit, which is 1 when no borrow occurs.
- R5: Code 3'b111 puts 1 in bit 0 when `opa` is less than `opb` as two's-complement values, and 0 otherwise. All higher result bits are 0. The comparison stays correct even when the subtraction overflows.
- R6: `zero` is 1 exactly when every result bit is 0, for every code.
- R7: For codes 3'b010 and 3'b110, `overflow` is 1 exactly when the signed result is out of range. This is the carry into the top bit XOR the carry out of it. An add of operands with opposite signs never raises it.
- R8: The codes 3'b011, 3'b100 and 3'b101 give an all-zero result, `overflow` 0 and `carry_out` 0.
- R9: For codes 3'b000, 3'b001 and 3'b111, `overflow` and `carry_out` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| op_code | input | 3 | Operation select |
| result | output | WIDTH | Selected result |
| zero | output | 1 | All result bits are zero |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry from the top bit of add or subtract |

## Verification
Because the block holds no state, a wrong internal value appears on the ports in the same evaluation as the stimulus that exposes it. The possible internal faults are a broken carry link, a wrong invert line, or a wrong feedback into bit 0. A four-bit instance is driven through every operand pair under every code, so any such fault shows up in the sweep. A 32-bit instance then takes the sign and carry corners plus random pairs, and each case is compared with arithmetic computed in the bench.

// File: rtl/bitslice_alu_pkg.sv
package bitslice_alu_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        PICK_AND  = 2'b00,
        PICK_OR   = 2'b01,
        PICK_SUM  = 2'b10,
        PICK_LESS = 2'b11
    } slice_pick_e;

    typedef struct packed {
        logic        invert_b;
        slice_pick_e pick;
        logic        arith;
        logic        valid;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import bitslice_alu_pkg::*;
(
    input  logic [2:0] op_code,
    output alu_ctrl_t  ctrl
);
    always_comb begin
        ctrl = '{invert_b: 1'b0, pick: PICK_AND, arith: 1'b0, valid: 1'b0};
        unique case (op_code)
            OP_AND: ctrl = '{invert_b: 1'b0, pick: PICK_AND,  arith: 1'b0, valid: 1'b1};
            OP_OR:  ctrl = '{invert_b: 1'b0, pick: PICK_OR,   arith: 1'b0, valid: 1'b1};
            OP_ADD: ctrl = '{invert_b: 1'b0, pick: PICK_SUM,  arith: 1'b1, valid: 1'b1};
            OP_SUB: ctrl = '{invert_b: 1'b1, pick: PICK_SUM,  arith: 1'b1, valid: 1'b1};
            OP_SLT: ctrl = '{invert_b: 1'b1, pick: PICK_LESS, arith: 1'b0, valid: 1'b1};
            default: ctrl = '{invert_b: 1'b0, pick: PICK_AND, arith: 1'b0, valid: 1'b0};
        endcase
    end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import bitslice_alu_pkg::*;
(
    input  logic        a,
    input  logic        b,
    input  logic        invert_b,
    input  logic        cin,
    input  logic        less,
    input  slice_pick_e pick,
    output logic        res,
    output logic        sum,
    output logic        cout
);
    logic bb;

    always_comb begin
        bb   = b ^ invert_b;
        sum  = a ^ bb ^ cin;
        cout = (a & bb) | (a & cin) | (bb & cin);
        unique case (pick)
            PICK_AND:  res = a & b;
            PICK_OR:   res = a | b;
            PICK_SUM:  res = sum;
            PICK_LESS: res = less;
            default:   res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
    import bitslice_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             invert_b,
    input  slice_pick_e      pick,
    output logic [WIDTH-1:0] res,
    output logic             carry_top_in,
    output logic             carry_top_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] less_in;
    logic             sign_fix;

    assign carry[0]      = invert_b;
    assign carry_top_in  = carry[MSB];
    assign carry_top_out = carry[WIDTH];
    assign sign_fix      = sum[MSB] ^ (carry[MSB] ^ carry[WIDTH]);

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        if (i == 0) begin : g_lsb
            assign less_in[i] = sign_fix;
        end else begin : g_upper
            assign less_in[i] = 1'b0;
        end
        alu_bit_slice u_slice (
            .a        (a[i]),
            .b        (b[i]),
            .invert_b (invert_b),
            .cin      (carry[i]),
            .less     (less_in[i]),
            .pick     (pick),
            .res      (res[i]),
            .sum      (sum[i]),
            .cout     (carry[i+1])
        );
    end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import bitslice_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [2:0]       op_code,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             carry_out
);
    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] chain_res;
    logic             c_in_top;
    logic             c_out_top;

    alu_op_decode u_decode (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    alu_slice_chain #(.WIDTH(WIDTH)) u_chain (
        .a             (opa),
        .b             (opb),
        .invert_b      (ctrl.invert_b),
        .pick          (ctrl.pick),
        .res           (chain_res),
        .carry_top_in  (c_in_top),
        .carry_top_out (c_out_top)
    );

    always_comb begin
        result    = ctrl.valid ? chain_res : '0;
        zero      = ~|result;
        overflow  = ctrl.arith & (c_in_top ^ c_out_top);
        carry_out = ctrl.arith & c_out_top;
    end
endmodule

// File: rtl/bitslice_alu_checker.sv
module bitslice_alu_checker #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [2:0]       op_code,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             overflow,
    input logic             carry_out
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        if (!$isunknown({opa, opb, op_code})) begin
            p_zero_flag_r6: assert (zero == (result == '0));
            if (op_code == 3'b010 && opa[MSB] != opb[MSB])
                p_mixed_sign_add_r7: assert (!overflow);
            if (op_code == 3'b010 && opa[MSB] == opb[MSB])
                p_same_sign_add_r7: assert (overflow == (result[MSB] != opa[MSB]));
            if (op_code == 3'b111)
                p_slt_upper_clear_r5: assert (result[MSB:1] == '0);
            if (op_code == 3'b011 || op_code == 3'b100 || op_code == 3'b101)
                p_unused_quiet_r8: assert (result == '0 && !overflow && !carry_out);
            if (op_code == 3'b000 || op_code == 3'b001 || op_code == 3'b111)
                p_no_flags_r9: assert (!overflow && !carry_out);
            if (op_code == 3'b000)
                p_and_subset_r1: assert ((result & ~opa) == '0);
        end
    end
endmodule

bind bitslice_alu bitslice_alu_checker #(.WIDTH(WIDTH)) u_checker (.*);

// File: tb/bitslice_alu_test.sv
module bitslice_alu_test;
    localparam int WIDE = 32;
    localparam int NARROW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [WIDE-1:0]   wa, wb, wres;
    logic [2:0]        wcode;
    logic              wz, wo, wc;
    logic [NARROW-1:0] na, nb, nres;
    logic [2:0]        ncode;
    logic              nz, no, nc;

    bitslice_alu #(.WIDTH(WIDE)) uut (
        .opa(wa), .opb(wb), .op_code(wcode),
        .result(wres), .zero(wz), .overflow(wo), .carry_out(wc));

    bitslice_alu #(.WIDTH(NARROW)) uut_narrow (
        .opa(na), .opb(nb), .op_code(ncode),
        .result(nres), .zero(nz), .overflow(no), .carry_out(nc));

    function automatic string req_of(input logic [2:0] code);
        case (code)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic model(input int w, input logic [63:0] a, input logic [63:0] b,
                         input logic [2:0] code, output logic [63:0] r,
                         output logic ov, output logic co);
        logic [63:0] mask, s;
        longint sa, sb;
        mask = (64'd1 << w) - 1;
        sa = a[w-1] ? longint'(a) - longint'(64'd1 << w) : longint'(a);
        sb = b[w-1] ? longint'(b) - longint'(64'd1 << w) : longint'(b);
        r = 0; ov = 0; co = 0;
        case (code)
            3'b000: r = a & b;
            3'b001: r = a | b;
            3'b010: begin
                s = a + b; r = s & mask; co = s[w];
                ov = (a[w-1] == b[w-1]) && (s[w-1] != a[w-1]);
            end
            3'b110: begin
                s = a + (~b & mask) + 64'd1; r = s & mask; co = s[w];
                ov = (a[w-1] != b[w-1]) && (s[w-1] != a[w-1]);
            end
            3'b111: r = (sa < sb) ? 64'd1 : 64'd0;
            default: r = 0;
        endcase
    endtask

    task automatic compare(input string req, input string what,
                           input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic judge(input int w, input logic [63:0] a, input logic [63:0] b,
                         input logic [2:0] code, input logic [63:0] r,
                         input logic z, input logic o, input logic c);
        logic [63:0] er;
        logic eo, ec;
        string rq;
        model(w, a, b, code, er, eo, ec);
        rq = req_of(code);
        compare(rq, "result", r, er);
        compare("R6", "zero", {63'd0, z}, {63'd0, er == 0});
        compare((code == 3'b010 || code == 3'b110) ? "R7" : (rq == "R8" ? "R8" : "R9"),
                "overflow", {63'd0, o}, {63'd0, eo});
        compare((code == 3'b010 || code == 3'b110) ? rq : (rq == "R8" ? "R8" : "R9"),
                "carry", {63'd0, c}, {63'd0, ec});
    endtask

    task automatic run_wide(input logic [31:0] a, input logic [31:0] b, input logic [2:0] code);
        @(posedge clk);
        wa = a; wb = b; wcode = code;
        @(negedge clk);
        judge(WIDE, {32'd0, a}, {32'd0, b}, code, {32'd0, wres}, wz, wo, wc);
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] corners [8];
        corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
        corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
        corners[4] = 32'hFFFF_FFFF; corners[5] = 32'h8000_0001;
        corners[6] = 32'h5555_AAAA; corners[7] = 32'hFFFF_FFFE;

        wa = '0; wb = '0; wcode = 3'b010;
        na = '0; nb = '0; ncode = 3'b000;
        @(negedge clk);
        // Idle state: zero operands added give zero result, zero flag set (R6, R3)
        judge(WIDE, 64'd0, 64'd0, 3'b010, {32'd0, wres}, wz, wo, wc);

        // Exhaustive sweep of the narrow instance over all codes (R1..R9)
        for (int code = 0; code < 8; code++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    @(posedge clk);
                    na = a[3:0]; nb = b[3:0]; ncode = code[2:0];
                    @(negedge clk);
                    judge(NARROW, 64'(a), 64'(b), code[2:0], {60'd0, nres}, nz, no, nc);
                end
            end
        end

        // Wide corners: overflow, borrow and slt under overflow (R4, R5, R7)
        for (int code = 0; code < 8; code++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_wide(corners[i], corners[j], code[2:0]);

        // Wide random operands (R1..R5)
        for (int k = 0; k < 1500; k++)
            run_wide($urandom, $urandom, 3'($urandom_range(0, 7)));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule